// File: doc/BRIEF.md
# One-Wire Temperature Sensor Responder

This block is the device end of a single-wire bus. It behaves as a temperature sensor that answers a bus master. The shared data line is open-drain and a pull-up holds it high. The block watches the line through `line_i` and can only pull it low, through `pull_low_o`. It never drives the line high.

A long low pulse from the master resets the bus. The block answers with a presence pulse and then takes command bytes in master-timed write slots. Only the skip-address command is accepted as the first byte. After it, one of two function commands follows. The convert command copies the `temp_i` port into an internal 16-bit scratch word. The read command returns that word in the master's read slots, least significant bit first.

A divider of the system clock makes a microsecond tick, and all timing is counted in that tick. The `phase_o` output shows which phase the exchange is in.

Top module: `ow_temp_responder`

## Requirements
- R1: The block only ever pulls the line low or releases it. It never pulls while idle, and it never pulls during a write slot.
- R2: A low level of at least RESET_MIN_US µs (480 by default), followed by a release, is a bus reset. This holds for any length up to 960 µs. A shorter low pulse seen while idle leaves the block idle.
- R3: After the release that ends a reset, the block waits PRES_WAIT_US µs (30). It then pulls the line low for PRES_LEN_US µs (120) as its presence pulse.
- R4: Write slots and read slots that come before any valid reset are ignored. The block stays idle and reads as all ones.
- R5: The first byte after presence must be 0xCC, the skip-address command, which moves the block on to wait for a function command. Any other first byte returns the block to idle, and later slots read as ones.
- R6: In a write slot the block samples the line SAMPLE_US µs (30) after the master's falling edge. High is bit 1 and low is bit 0, and bytes arrive least significant bit first.
- R7: Function command 0x44 latches `temp_i` into the scratch word and returns the block to idle. Later changes on `temp_i` do not alter the word until the next 0x44.
- R8: Function command 0xBE sends the 16-bit two's-complement word, least significant bit first. For a 0 bit the block holds the line low from the falling edge until about HOLD_US µs (30) after it. For a 1 bit it leaves the line alone. After 16 slots the block is idle, and further slots read as ones.
- R9: A reset that arrives partway through a command byte throws away the partial byte and starts a fresh presence sequence.
- R10: After a synchronous reset, the scratch word holds RESET_TEMP (0x0550) until the first 0x44.
- R11: `phase_o` encodes the phase as follows: 0 idle, 1 presence (waiting or pulling), 2 command receive, 3 data send.
- R12: A function command other than 0x44 or 0xBE returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 1 | Level seen on the shared bus line |
| temp_i | input | 16 | Temperature sample, two's complement, 1/16 °C per LSB |
| pull_low_o | output | 1 | Output enable: 1 pulls the line low, 0 releases it |
| phase_o | output | 2 | Current phase: 0 idle, 1 presence, 2 command, 3 send |

## Verification
The hardest case to reach from the ports is a reset that lands partway through a command byte. The master's long low pulse starts like an ordinary write slot, so a stray bit is sampled before the reset is recognised. That stray bit must not carry over into the next byte. The bench sends a skip-address byte and then the first four bits of a read command. It then issues a full reset, followed by a complete skip-address and read exchange, and compares the returned word with its model. If the bit counter kept the partial bits, the byte framing would slip and the read would fail. On every clock the bench also checks that the block pulls the line only inside windows where its model expects a pull.

// File: rtl/ow_resp_pkg.sv
// Shared types and command codes for the one-wire responder.
// Assumes: the phase encoding is observed outside the block and must stay fixed.
package ow_resp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRES = 2'd1,
        PH_CMD  = 2'd2,
        PH_SEND = 2'd3
    } phase_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PWAIT,
        S_PPULL,
        S_ROMCMD,
        S_FNCMD,
        S_SEND
    } resp_st_e;

    localparam logic [7:0] CMD_SKIP_ADDR = 8'hCC;
    localparam logic [7:0] CMD_CONVERT   = 8'h44;
    localparam logic [7:0] CMD_READ_PAD  = 8'hBE;

endpackage

// File: rtl/ow_us_tick.sv
// Microsecond tick generator: emits a one-cycle pulse every CLK_PER_US clocks.
// Assumes: CLK_PER_US >= 1 and the system clock is free-running.
module ow_us_tick #(
    parameter int CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = $clog2(CLK_PER_US + 1);

    logic [CW-1:0] div_q;

    // Divider counter, wrapping at CLK_PER_US-1, with a registered tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            tick_o <= 1'b0;
        end else if (div_q == CW'(CLK_PER_US - 1)) begin
            div_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            div_q  <= div_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

    generate
        if (CLK_PER_US > 1) begin : g_spacing
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o); // R3
        end
    endgenerate

endmodule

// File: rtl/ow_line_mon.sv
// Line monitor: synchronises the bus line, flags falling edges and detects a
// bus reset (a low level of RESET_MIN_US or more that ends in a rise).
// Assumes: line_i is asynchronous to clk; us_tick pulses once per microsecond.
module ow_line_mon #(
    parameter int RESET_MIN_US = 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic line_i,
    output logic line_o,
    output logic fall_o,
    output logic reset_o
);
    localparam int LW = $clog2(RESET_MIN_US + 1);

    logic [1:0]    sync_q;
    logic          prev_q;
    logic [LW-1:0] low_us_q;
    logic          rise;

    // Two-stage synchroniser plus a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            prev_q <= sync_q[1];
        end
    end

    assign line_o = sync_q[1];
    assign fall_o = prev_q & ~sync_q[1];
    assign rise   = ~prev_q & sync_q[1];

    // Saturating count of microseconds spent low since the last falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_us_q <= '0;
        end else if (fall_o) begin
            low_us_q <= '0;
        end else if (us_tick && !line_o && low_us_q != LW'(RESET_MIN_US)) begin
            low_us_q <= low_us_q + 1'b1;
        end
    end

    assign reset_o = rise && (low_us_q == LW'(RESET_MIN_US));

    AST_LOW_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        low_us_q <= LW'(RESET_MIN_US)); // R2

    AST_RESET_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        reset_o |=> line_o); // R2

endmodule

// File: rtl/ow_resp_ctrl.sv
// Responder sequencer: presence timing, write-slot sampling, command decode,
// scratch word latch and read-slot bit sending.
// Assumes: line/fall/reset_det come from ow_line_mon; us_tick from ow_us_tick.
module ow_resp_ctrl
    import ow_resp_pkg::*;
#(
    parameter int                PRES_WAIT_US = 30,
    parameter int                PRES_LEN_US  = 120,
    parameter int                SAMPLE_US    = 30,
    parameter int                HOLD_US      = 30,
    parameter int                WORD_W       = 16,
    parameter logic [WORD_W-1:0] RESET_TEMP   = 16'h0550
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              line,
    input  logic              fall,
    input  logic              reset_det,
    input  logic [WORD_W-1:0] temp_i,
    output logic              pull_o,
    output logic [1:0]        phase_o
);
    localparam int T1   = (PRES_WAIT_US > PRES_LEN_US) ? PRES_WAIT_US : PRES_LEN_US;
    localparam int T2   = (SAMPLE_US > HOLD_US) ? SAMPLE_US : HOLD_US;
    localparam int TMAX = (T1 > T2) ? T1 : T2;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int BW   = $clog2(WORD_W + 1);

    resp_st_e          st_q;
    logic [TW-1:0]     tmr_q;
    logic [BW-1:0]     bit_q;
    logic [7:0]        rx_q;
    logic              slot_q;
    logic [WORD_W-1:0] pad_q;
    logic [WORD_W-1:0] tx_q;
    logic [7:0]        rx_next;

    assign rx_next = {line, rx_q[7:1]};

    // Main sequencer: a bus reset overrides every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            tmr_q  <= '0;
            bit_q  <= '0;
            rx_q   <= '0;
            slot_q <= 1'b0;
            pad_q  <= RESET_TEMP;
            tx_q   <= '1;
            pull_o <= 1'b0;
        end else if (reset_det) begin
            st_q   <= S_PWAIT;
            tmr_q  <= '0;
            bit_q  <= '0;
            slot_q <= 1'b0;
            pull_o <= 1'b0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    pull_o <= 1'b0;
                    slot_q <= 1'b0;
                end
                S_PWAIT: begin
                    if (us_tick) begin
                        if (tmr_q == TW'(PRES_WAIT_US - 1)) begin
                            st_q   <= S_PPULL;
                            tmr_q  <= '0;
                            pull_o <= 1'b1;
                        end else begin
                            tmr_q <= tmr_q + 1'b1;
                        end
                    end
                end
                S_PPULL: begin
                    if (us_tick) begin
                        if (tmr_q == TW'(PRES_LEN_US - 1)) begin
                            st_q   <= S_ROMCMD;
                            tmr_q  <= '0;
                            bit_q  <= '0;
                            pull_o <= 1'b0;
                        end else begin
                            tmr_q <= tmr_q + 1'b1;
                        end
                    end
                end
                S_ROMCMD, S_FNCMD: begin
                    if (fall) begin
                        slot_q <= 1'b1;
                        tmr_q  <= '0;
                    end else if (slot_q && us_tick) begin
                        if (tmr_q == TW'(SAMPLE_US - 1)) begin
                            slot_q <= 1'b0;
                            rx_q   <= rx_next;
                            if (bit_q == BW'(7)) begin
                                bit_q <= '0;
                                if (st_q == S_ROMCMD) begin
                                    st_q <= (rx_next == CMD_SKIP_ADDR) ? S_FNCMD : S_IDLE;
                                end else if (rx_next == CMD_CONVERT) begin
                                    pad_q <= temp_i;
                                    st_q  <= S_IDLE;
                                end else if (rx_next == CMD_READ_PAD) begin
                                    tx_q <= pad_q;
                                    st_q <= S_SEND;
                                end else begin
                                    st_q <= S_IDLE;
                                end
                            end else begin
                                bit_q <= bit_q + 1'b1;
                            end
                        end else begin
                            tmr_q <= tmr_q + 1'b1;
                        end
                    end
                end
                S_SEND: begin
                    if (fall) begin
                        slot_q <= 1'b1;
                        tmr_q  <= '0;
                        pull_o <= ~tx_q[0];
                    end else if (slot_q && us_tick) begin
                        if (tmr_q == TW'(HOLD_US - 1)) begin
                            slot_q <= 1'b0;
                            pull_o <= 1'b0;
                            tx_q   <= {1'b1, tx_q[WORD_W-1:1]};
                            if (bit_q == BW'(WORD_W - 1)) begin
                                bit_q <= '0;
                                st_q  <= S_IDLE;
                            end else begin
                                bit_q <= bit_q + 1'b1;
                            end
                        end else begin
                            tmr_q <= tmr_q + 1'b1;
                        end
                    end
                end
                default: begin
                    st_q   <= S_IDLE;
                    pull_o <= 1'b0;
                end
            endcase
        end
    end

    // Phase encoding seen at the block edge.
    always_comb begin
        case (st_q)
            S_PWAIT, S_PPULL:  phase_o = PH_PRES;
            S_ROMCMD, S_FNCMD: phase_o = PH_CMD;
            S_SEND:            phase_o = PH_SEND;
            default:           phase_o = PH_IDLE;
        endcase
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE) |-> !pull_o); // R1

    AST_CMD_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_ROMCMD || st_q == S_FNCMD) |-> !pull_o); // R1

    AST_RESET_TO_PRES: assert property (@(posedge clk) disable iff (!rst_n)
        reset_det |=> (phase_o == PH_PRES) && !pull_o); // R2

    AST_PRES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_PPULL) |-> pull_o); // R3

    AST_SEND_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_o && st_q == S_SEND) |-> (slot_q && tmr_q < TW'(HOLD_US))); // R8

    AST_PAD_ONLY_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_FNCMD) |=> $stable(pad_q)); // R7

endmodule

// File: rtl/ow_temp_responder.sv
// One-wire temperature responder top: ties together the tick divider, the
// line monitor and the sequencer.
// Assumes: the bus line is pulled high outside; pull_low_o drives an open-drain pad.
module ow_temp_responder #(
    parameter int           CLK_PER_US   = 50,
    parameter int           RESET_MIN_US = 480,
    parameter int           PRES_WAIT_US = 30,
    parameter int           PRES_LEN_US  = 120,
    parameter int           SAMPLE_US    = 30,
    parameter int           HOLD_US      = 30,
    parameter logic [15:0]  RESET_TEMP   = 16'h0550
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line_i,
    input  logic [15:0] temp_i,
    output logic        pull_low_o,
    output logic [1:0]  phase_o
);
    logic us_tick;
    logic line_s;
    logic fall;
    logic reset_det;

    ow_us_tick #(.CLK_PER_US(CLK_PER_US)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (us_tick)
    );

    ow_line_mon #(.RESET_MIN_US(RESET_MIN_US)) mon_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .us_tick (us_tick),
        .line_i  (line_i),
        .line_o  (line_s),
        .fall_o  (fall),
        .reset_o (reset_det)
    );

    ow_resp_ctrl #(
        .PRES_WAIT_US (PRES_WAIT_US),
        .PRES_LEN_US  (PRES_LEN_US),
        .SAMPLE_US    (SAMPLE_US),
        .HOLD_US      (HOLD_US),
        .WORD_W       (16),
        .RESET_TEMP   (RESET_TEMP)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_tick   (us_tick),
        .line      (line_s),
        .fall      (fall),
        .reset_det (reset_det),
        .temp_i    (temp_i),
        .pull_o    (pull_low_o),
        .phase_o   (phase_o)
    );

endmodule

// File: tb/ow_temp_responder_tb_top.sv
// Bench: a behavioural bus master plus a model of the expected word and of the
// windows in which the responder may pull; the pull window is checked every clock.
module ow_temp_responder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CPU        = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] temp = 16'h0000;
    logic        m_pull = 1'b0;
    logic        dut_pull;
    logic [1:0]  phase;
    logic        line_w;
    int          total = 0;
    int          bad = 0;
    int          quiet_viol = 0;
    bit          pull_ok = 1'b0;
    bit          done = 1'b0;
    logic [15:0] model_word = 16'h0550;

    assign line_w = !(m_pull || dut_pull);

    always #(CLK_PERIOD / 2) clk = ~clk;

    ow_temp_responder #(.CLK_PER_US(CPU)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line_w),
        .temp_i     (temp),
        .pull_low_o (dut_pull),
        .phase_o    (phase)
    );

    // Every-clock comparison: a pull is legal only where the model allows it (R1).
    always @(negedge clk) begin
        if (rst_n && dut_pull && !pull_ok) quiet_viol++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (n * CPU) @(negedge clk);
    endtask

    task automatic write_bit(input logic b);
        pull_ok = 1'b0;
        m_pull  = 1'b1;
        wait_us(b ? 6 : 60);
        m_pull  = 1'b0;
        wait_us(b ? 64 : 10);
    endtask

    task automatic write_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) write_bit(v[i]);
    endtask

    task automatic read_bit(input logic exp_b, output logic got);
        pull_ok = (exp_b == 1'b0);
        m_pull  = 1'b1;
        wait_us(2);
        m_pull  = 1'b0;
        wait_us(10);
        got = line_w;
        wait_us(28);
        if (exp_b == 1'b0) chk("R8 release after hold", dut_pull, 0);
        pull_ok = 1'b0;
        wait_us(30);
    endtask

    task automatic read_word(input logic [15:0] exp_w, input string req);
        logic [15:0] w;
        logic        b;
        for (int i = 0; i < 16; i++) begin
            read_bit(exp_w[i], b);
            w[i] = b;
        end
        chk(req, w, exp_w);
    endtask

    task automatic bus_reset(input int low_us);
        pull_ok = 1'b0;
        m_pull  = 1'b1;
        wait_us(low_us);
        m_pull  = 1'b0;
        wait_us(10);
        chk("R3 no pull before wait ends", dut_pull, 0);
        pull_ok = 1'b1;
        wait_us(50);
        chk("R3 presence pulling at 60us", dut_pull, 1);
        chk("R11 phase presence", phase, 1);
        wait_us(80);
        chk("R3 presence pulling at 140us", dut_pull, 1);
        wait_us(30);
        chk("R3 presence released at 170us", dut_pull, 0);
        pull_ok = 1'b0;
        wait_us(130);
        chk("R11 phase command after presence", phase, 2);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            total++;
            if (quiet_viol != 0) begin
                bad++;
                $display("FAIL R1 pull outside allowed window actual=%0d expected=0", quiet_viol);
            end
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        logic b;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wait_us(5);
        chk("R11 reset phase idle", phase, 0);
        chk("R1 reset no pull", dut_pull, 0);

        // R4: slots before any reset are ignored.
        write_byte(8'hCC);
        write_byte(8'hBE);
        read_word(16'hFFFF, "R4 reads ones before reset");
        chk("R4 phase idle", phase, 0);

        // R2: a 300us low is not a reset.
        m_pull = 1'b1;
        wait_us(300);
        m_pull = 1'b0;
        wait_us(200);
        chk("R2 short pulse ignored", phase, 0);

        // R10 / R8: power-up word, then trailing ones.
        bus_reset(500);
        write_byte(8'hCC);
        chk("R5 skip accepted phase", phase, 2);
        write_byte(8'hBE);
        chk("R11 phase send", phase, 3);
        read_word(model_word, "R10 power-up word");
        chk("R8 idle after 16 bits", phase, 0);
        for (int i = 0; i < 8; i++) begin
            read_bit(1'b1, b);
            chk("R8 trailing bit one", b, 1);
        end

        // R7: convert latches temp_i; later changes ignored.
        temp = 16'hFE6F;
        bus_reset(500);
        write_byte(8'hCC);
        write_byte(8'h44);
        model_word = temp;
        chk("R7 idle after convert", phase, 0);
        temp = 16'h1234;
        bus_reset(500);
        write_byte(8'hCC);
        write_byte(8'hBE);
        read_word(model_word, "R7 negative word kept");

        // R2 upper bound and R6 with a different bit pattern.
        temp = 16'h07D0;
        bus_reset(960);
        write_byte(8'hCC);
        write_byte(8'h44);
        model_word = temp;
        bus_reset(500);
        write_byte(8'hCC);
        write_byte(8'hBE);
        read_word(model_word, "R6 R2 positive word");

        // R5: wrong first byte.
        bus_reset(500);
        write_byte(8'h33);
        chk("R5 wrong rom byte idle", phase, 0);
        for (int i = 0; i < 4; i++) begin
            read_bit(1'b1, b);
            chk("R5 ignored slot reads one", b, 1);
        end

        // R12: unknown function command.
        bus_reset(500);
        write_byte(8'hCC);
        write_byte(8'hA5);
        chk("R12 unknown command idle", phase, 0);

        // R9: reset mid-byte drops the partial byte.
        bus_reset(500);
        write_byte(8'hCC);
        for (int i = 0; i < 4; i++) write_bit(CMD_LOW_NIBBLE[i]);
        bus_reset(500);
        write_byte(8'hCC);
        write_byte(8'hBE);
        chk("R9 phase send after restart", phase, 3);
        read_word(model_word, "R9 word after mid-byte reset");

        finish_up();
    end

    localparam logic [3:0] CMD_LOW_NIBBLE = 4'hE;

endmodule